// File: doc/BRIEF.md
# DMA Command Executor with Address Counters

This block carries out the one-byte control commands of a DMA controller once the control-port sequencer has recognised them as commands. It holds the two port address counters, the transferred-byte counter, the match-found and end-of-block status flags, the channel enable, the interrupt enable, a pending-step flag and the forced-ready level. The sequencer hands over each command as a one-cycle strobe with its byte. The start addresses, both port flag bytes and the mode byte that carries the ready polarity are supplied as plain inputs.

The transfer engine that moves data is outside this block. It reports to the block through four event inputs. One asks for a deferred address step, one reports a match, one reports the end of a block and one counts a transferred byte. The distinctive command is Continue. It applies any deferred step to each port counter in the direction that port's own flag byte selects. It then resumes the channel without reloading the start addresses.

Top module: `dma_cmd_exec`

## Requirements
- R1: After reset both address counters and the byte counter are 0. Match, end-of-block, enable, interrupt enable, pending-step and `wr0_clr` are 0, and `rdy_level` is 1.
- R2: Command 0x87 clears the pending-step flag and sets the enable.
- R3: Command 0x8B clears both the match and the end-of-block flag.
- R4: Command 0xAB sets the interrupt enable, and command 0xAF clears it.
- R5: Command 0xB3 loads `rdy_level` with bit 3 of `mode_byte`.
- R6: Command 0xC3 raises `wr0_clr` for exactly the following cycle. It also clears the pending-step flag and the interrupt enable, and it leaves the enable unchanged.
- R7: Command 0xCF loads `addr_a` from `start_a` and `addr_b` from `start_b`. It also zeroes the byte counter and clears both status flags.
- R8: Command 0xD3 with the pending-step flag set clears that flag and steps each port counter by bits 5:4 of its flag byte. Code 00 decrements, code 01 increments, and codes 10 and 11 hold the counter. Without the flag set, no counter moves. In both cases the command zeroes the byte counter, clears both status flags and sets the enable.
- R9: Address steps wrap modulo 2^16: 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.
- R10: Commands 0x83, 0xC7 and 0xCB, and every byte not listed in R2 to R8, change no output.
- R11: `step_req` sets the pending-step flag, `match_evt` sets match, `end_evt` sets end-of-block and `xfer_tick` increments the byte counter. A command that clears one of these in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_byte | input | 8 | Command code |
| start_a | input | 16 | Programmed port A start address |
| start_b | input | 16 | Programmed port B start address |
| flags_a | input | 8 | Port A flag byte, bits 5:4 give the direction code |
| flags_b | input | 8 | Port B flag byte, bits 5:4 give the direction code |
| mode_byte | input | 8 | Mode byte, bit 3 is the ready level |
| step_req | input | 1 | Engine asks for a deferred address step |
| match_evt | input | 1 | Engine found a match |
| end_evt | input | 1 | Engine reached end of block |
| xfer_tick | input | 1 | One byte transferred |
| addr_a | output | 16 | Port A address counter |
| addr_b | output | 16 | Port B address counter |
| byte_cnt | output | 16 | Byte counter |
| match_flag | output | 1 | Match-found status |
| endb_flag | output | 1 | End-of-block status |
| dma_en | output | 1 | Channel enable |
| int_en | output | 1 | Interrupt enable |
| step_pend | output | 1 | Pending-step flag |
| rdy_level | output | 1 | Forced ready level |
| wr0_clr | output | 1 | Pulse asking the sequencer to clear its transfer-kind bits |

## Verification
The assertions assume that `cmd_valid` lasts a single cycle per command. They also assume that the start addresses, flag bytes and mode byte are stable while a command is captured. Their clear-beats-set checks rely on the precedence rule of R11 and not on the absence of engine events. The bench drives every input a half cycle away from the capturing edge and keeps each command strobe to one cycle. Engine events overlap a command only in the dedicated precedence checks.

// File: rtl/dma_cmd_exec.sv
module dma_cmd_exec #(
  parameter int AW = 16,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic [AW-1:0] start_a,
  input  logic [AW-1:0] start_b,
  input  logic [7:0]    flags_a,
  input  logic [7:0]    flags_b,
  input  logic [7:0]    mode_byte,
  input  logic          step_req,
  input  logic          match_evt,
  input  logic          end_evt,
  input  logic          xfer_tick,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [BW-1:0] byte_cnt,
  output logic          match_flag,
  output logic          endb_flag,
  output logic          dma_en,
  output logic          int_en,
  output logic          step_pend,
  output logic          rdy_level,
  output logic          wr0_clr
);
  localparam logic [7:0] OP_ENABLE = 8'h87;
  localparam logic [7:0] OP_STCLR  = 8'h8B;
  localparam logic [7:0] OP_IEON   = 8'hAB;
  localparam logic [7:0] OP_IEOFF  = 8'hAF;
  localparam logic [7:0] OP_FRDY   = 8'hB3;
  localparam logic [7:0] OP_RESET  = 8'hC3;
  localparam logic [7:0] OP_LOAD   = 8'hCF;
  localparam logic [7:0] OP_CONT   = 8'hD3;

  logic hit_en, hit_st, hit_ieon, hit_ieoff, hit_frdy, hit_rst, hit_load, hit_cont;
  assign hit_en    = cmd_valid && cmd_byte == OP_ENABLE;
  assign hit_st    = cmd_valid && cmd_byte == OP_STCLR;
  assign hit_ieon  = cmd_valid && cmd_byte == OP_IEON;
  assign hit_ieoff = cmd_valid && cmd_byte == OP_IEOFF;
  assign hit_frdy  = cmd_valid && cmd_byte == OP_FRDY;
  assign hit_rst   = cmd_valid && cmd_byte == OP_RESET;
  assign hit_load  = cmd_valid && cmd_byte == OP_LOAD;
  assign hit_cont  = cmd_valid && cmd_byte == OP_CONT;

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] v, input logic [1:0] code);
    case (code)
      2'b00:   stepped = v - 1'b1;
      2'b01:   stepped = v + 1'b1;
      default: stepped = v;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_a     <= '0;
      addr_b     <= '0;
      byte_cnt   <= '0;
      match_flag <= 1'b0;
      endb_flag  <= 1'b0;
      dma_en     <= 1'b0;
      int_en     <= 1'b0;
      step_pend  <= 1'b0;
      rdy_level  <= 1'b1;
      wr0_clr    <= 1'b0;
    end else begin
      wr0_clr <= hit_rst;
      if (step_req)  step_pend  <= 1'b1;
      if (match_evt) match_flag <= 1'b1;
      if (end_evt)   endb_flag  <= 1'b1;
      if (xfer_tick) byte_cnt   <= byte_cnt + 1'b1;
      if (hit_en) begin
        step_pend <= 1'b0;
        dma_en    <= 1'b1;
      end
      if (hit_st) begin
        match_flag <= 1'b0;
        endb_flag  <= 1'b0;
      end
      if (hit_ieon)  int_en <= 1'b1;
      if (hit_ieoff) int_en <= 1'b0;
      if (hit_frdy)  rdy_level <= mode_byte[3];
      if (hit_rst) begin
        step_pend <= 1'b0;
        int_en    <= 1'b0;
      end
      if (hit_load) begin
        addr_a     <= start_a;
        addr_b     <= start_b;
        byte_cnt   <= '0;
        match_flag <= 1'b0;
        endb_flag  <= 1'b0;
      end
      if (hit_cont) begin
        if (step_pend) begin
          addr_a <= stepped(addr_a, flags_a[5:4]);
          addr_b <= stepped(addr_b, flags_b[5:4]);
        end
        step_pend  <= 1'b0;
        byte_cnt   <= '0;
        match_flag <= 1'b0;
        endb_flag  <= 1'b0;
        dma_en     <= 1'b1;
      end
    end
  end

  AST_EN_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en) |-> $past(hit_en || hit_cont)); // R2
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_st || hit_load || hit_cont) |=> (!match_flag && !endb_flag)); // R3
  AST_IE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ieon |=> int_en); // R4
  AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_frdy |=> rdy_level == $past(mode_byte[3])); // R5
  AST_WR0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_clr |-> $past(hit_rst)); // R6
  AST_RST_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rst |=> dma_en == $past(dma_en)); // R6
  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    hit_load |=> addr_a == $past(start_a)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_load || hit_cont) |=> $stable(addr_a) && $stable(addr_b)); // R10
  AST_CONT_NOPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cont && !step_pend) |=> $stable(addr_a)); // R8
endmodule

// File: tb/tb_dma_cmd_exec.sv
module tb_dma_cmd_exec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [15:0] start_a = 16'h0, start_b = 16'h0;
  logic [7:0] flags_a = 8'h0, flags_b = 8'h0, mode_byte = 8'h0;
  logic step_req = 1'b0, match_evt = 1'b0, end_evt = 1'b0, xfer_tick = 1'b0;
  logic [15:0] addr_a, addr_b, byte_cnt;
  logic match_flag, endb_flag, dma_en, int_en, step_pend, rdy_level, wr0_clr;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] e_a, e_b, e_bc;
  logic e_m, e_e, e_en, e_ie, e_p, e_rdy, e_w;

  always #4 clk = ~clk;

  dma_cmd_exec dut (.*);

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "addr_a", addr_a, e_a);
    chk(req, "addr_b", addr_b, e_b);
    chk(req, "byte_cnt", byte_cnt, e_bc);
    chk(req, "match", {15'd0, match_flag}, {15'd0, e_m});
    chk(req, "endb", {15'd0, endb_flag}, {15'd0, e_e});
    chk(req, "en", {15'd0, dma_en}, {15'd0, e_en});
    chk(req, "int_en", {15'd0, int_en}, {15'd0, e_ie});
    chk(req, "pend", {15'd0, step_pend}, {15'd0, e_p});
    chk(req, "rdy", {15'd0, rdy_level}, {15'd0, e_rdy});
    chk(req, "wr0_clr", {15'd0, wr0_clr}, {15'd0, e_w});
  endtask

  function automatic logic [15:0] ref_step(input logic [15:0] v, input logic [1:0] c);
    if (c == 2'd0) return v + 16'hFFFF;
    if (c == 2'd1) return v + 16'd1;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    e_a = 0; e_b = 0; e_bc = 0; e_m = 0; e_e = 0; e_en = 0; e_ie = 0; e_p = 0; e_rdy = 1; e_w = 0;
  endtask

  task automatic model_cmd(input logic [7:0] c);
    e_w = (c == 8'hC3);
    case (c)
      8'h87: begin e_p = 0; e_en = 1; end
      8'h8B: begin e_m = 0; e_e = 0; end
      8'hAB: e_ie = 1;
      8'hAF: e_ie = 0;
      8'hB3: e_rdy = mode_byte[3];
      8'hC3: begin e_p = 0; e_ie = 0; end
      8'hCF: begin e_a = start_a; e_b = start_b; e_bc = 0; e_m = 0; e_e = 0; end
      8'hD3: begin
        if (e_p) begin e_a = ref_step(e_a, flags_a[5:4]); e_b = ref_step(e_b, flags_b[5:4]); end
        e_p = 0; e_bc = 0; e_m = 0; e_e = 0; e_en = 1;
      end
      default: ;
    endcase
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = c;
    model_cmd(c);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic events(input int ticks);
    @(negedge clk); step_req = 1; match_evt = 1; end_evt = 1;
    @(negedge clk); step_req = 0; match_evt = 0; end_evt = 0;
    e_p = 1; e_m = 1; e_e = 1; e_w = 0;
    for (int k = 0; k < ticks; k++) begin
      @(negedge clk); xfer_tick = 1;
      @(negedge clk); xfer_tick = 0;
      e_bc = e_bc + 16'd1;
    end
  endtask

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      8'h87: return "R2";
      8'h8B: return "R3";
      8'hAB, 8'hAF: return "R4";
      8'hB3: return "R5";
      8'hC3: return "R6";
      8'hCF: return "R7";
      8'hD3: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    do_reset();
    @(negedge clk);
    chk_all("R1");

    // R2..R8, R10: sweep all 256 command bytes from a primed state
    for (int c = 0; c < 256; c++) begin
      do_reset();
      start_a = 16'h1000 + c[15:0]; start_b = 16'h8000 - c[15:0];
      flags_a = {2'b00, c[1:0], 4'h0}; flags_b = {2'b00, c[3:2], 4'h0};
      mode_byte = {4'h0, c[0], 3'b0};
      cmd(8'hCF);
      if (c[0]) cmd(8'h87);
      cmd(8'hAB);
      start_a = 16'h2222 + c[15:0]; start_b = 16'h4444;
      mode_byte = {4'h0, ~c[0], 3'b0};
      events(c % 3 + 1);
      cmd(c[7:0]);
      chk_all(tag_of(c[7:0]));
      @(negedge clk); e_w = 0;
      chk("R6", "wr0_clr one cycle", {15'd0, wr0_clr}, 16'd0);
    end

    // R8/R9: every direction pair, at both wrap boundaries
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 16; d++) begin
        do_reset();
        start_a = s ? 16'h0000 : 16'hFFFF; start_b = s ? 16'hFFFF : 16'h0000;
        flags_a = {2'b00, d[1:0], 4'h5}; flags_b = {2'b11, d[3:2], 4'hA};
        cmd(8'hCF);
        events(1);
        cmd(8'hD3);
        chk_all("R9");
        cmd(8'hD3);
        chk_all("R8");
      end
    end

    // R11: engine events, and command clears winning in the same cycle
    do_reset();
    events(5);
    chk_all("R11");
    @(negedge clk); cmd_valid = 1; cmd_byte = 8'h8B; match_evt = 1; end_evt = 1; step_req = 1;
    @(negedge clk); cmd_valid = 0; match_evt = 0; end_evt = 0; step_req = 0;
    e_m = 0; e_e = 0;
    chk_all("R11");
    @(negedge clk); cmd_valid = 1; cmd_byte = 8'h87; step_req = 1;
    @(negedge clk); cmd_valid = 0; step_req = 0;
    e_p = 0; e_en = 1;
    chk_all("R11");
    @(negedge clk); cmd_valid = 1; cmd_byte = 8'hCF; xfer_tick = 1; start_a = 16'h0ABC; start_b = 16'h0DEF;
    @(negedge clk); cmd_valid = 0; xfer_tick = 0;
    e_a = 16'h0ABC; e_b = 16'h0DEF; e_bc = 0;
    chk_all("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule